// File: doc/BRIEF.md
# ATM Cell Header Check and Single-Bit Repair

This block sits after cell delineation in a receive path for ATM cells that is already in sync. Every cell header is five bytes. The first four bytes carry routing and control fields. The fifth byte is a check byte derived from the first four. For each header the block recomputes the check, forms the syndrome and decides whether the cell passes or is dropped. When the error is correctable, it also repairs one bit.

A two-state mode machine controls how far the block trusts a single-bit repair. In repair mode, an isolated single-bit error is corrected and the cell is kept. Once any error has been seen, the block moves to a cautious mode. In that mode every errored header is discarded, and only a clean header returns the block to repair mode. A delineation-loss input forces repair mode, so the next header after a resync is treated as fresh. Each decision is a registered result that appears one clock after the header strobe.

Top module: `hec_guard`

## Requirements
- R1: A decision (`dec_valid` high) is presented exactly one clock after each cycle with `hdr_valid` high. In cycles with no decision, `dec_valid`, `dec_pass`, `dec_fixed` and `dec_err` are all low.
- R2: The header bus places byte 1 at bits [39:32] and the check byte at [7:0]. The expected check byte is CRC-8 with generator x^8+x^2+x+1 and a zero start value, computed MSB first over bits [39:8], then XORed with 0x55. `dec_err` is high exactly when the received check byte differs from this value.
- R3: In repair mode, a header without error passes, `dec_fixed` stays low and the block stays in repair mode.
- R4: In repair mode, a header whose syndrome equals that of one of the 40 single-bit errors has that bit inverted. The cell passes with `dec_fixed` high and the block enters cautious mode.
- R5: In repair mode, a header with any other nonzero syndrome (such as any two-bit error) is dropped without repair, and the block enters cautious mode.
- R6: In cautious mode, every header with `dec_err` high is dropped, including single-bit errors, and the block stays in cautious mode.
- R7: In cautious mode, a header without error passes and the block returns to repair mode.
- R8: After reset the block is in repair mode.
- R9: `sync_lost` high in a cycle puts the block in repair mode for every later header. A header strobed in that same cycle is still judged in the mode the block was already in.
- R10: `hdr_out` equals the strobed header with the identified bit inverted when `dec_fixed` is high, and the header unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_lost | input | 1 | Delineation lost; forces repair mode |
| hdr_valid | input | 1 | Header strobe |
| hdr_in | input | 40 | Received header, byte 1 in [39:32], check byte in [7:0] |
| dec_valid | output | 1 | Decision present |
| dec_pass | output | 1 | Cell is kept |
| dec_fixed | output | 1 | One bit of the header was repaired |
| dec_err | output | 1 | Syndrome was nonzero |
| hdr_out | output | 40 | Header after repair |

## Verification
The bench builds the block with its default five-byte header and the standard generator and coset. At that size every single-bit error position (40) and every two-bit error pair (780) fits into one short run. Each single-bit case is run in both modes, and each pair is run from repair mode. The mode sequence is tracked with an arithmetic model in the bench. Reset and delineation loss are applied both mid-stream and coincident with a strobe, which covers the same-cycle ordering rule.

// File: rtl/hec_pkg.sv
package hec_pkg;
  localparam int HEC_W    = 8;
  localparam int HDR_W    = 40;
  localparam int DATA_W   = HDR_W - HEC_W;
  localparam logic [HEC_W-1:0] HEC_POLY  = 8'h07;
  localparam logic [HEC_W-1:0] HEC_COSET = 8'h55;

  typedef enum logic {MODE_REPAIR = 1'b0, MODE_CAUTIOUS = 1'b1} hec_mode_e;

  // Serial CRC remainder, MSB first, zero start.
  function automatic logic [HEC_W-1:0] hec_crc(input logic [DATA_W-1:0] d,
                                               input logic [HEC_W-1:0] poly);
    logic [HEC_W-1:0] r;
    logic fb;
    r = '0;
    for (int k = DATA_W - 1; k >= 0; k--) begin
      fb = r[HEC_W-1] ^ d[k];
      r  = {r[HEC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/hec_syndrome.sv
module hec_syndrome
  import hec_pkg::*;
#(
  parameter logic [HEC_W-1:0] POLY  = HEC_POLY,
  parameter logic [HEC_W-1:0] COSET = HEC_COSET
) (
  input  logic [HDR_W-1:0] hdr,
  output logic [HEC_W-1:0] syn
);
  always_comb begin
    syn = hec_crc(hdr[HDR_W-1:HEC_W], POLY) ^ COSET ^ hdr[HEC_W-1:0];
  end
endmodule

// File: rtl/hec_bitfix.sv
module hec_bitfix
  import hec_pkg::*;
#(
  parameter logic [HEC_W-1:0] POLY = HEC_POLY
) (
  input  logic [HEC_W-1:0] syn,
  output logic [HDR_W-1:0] flip_mask,
  output logic             single
);
  localparam logic [DATA_W-1:0] ONE_D = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [HEC_W-1:0]  ONE_C = {{(HEC_W-1){1'b0}}, 1'b1};

  for (genvar i = 0; i < HDR_W; i++) begin : g_pos
    if (i < HEC_W) begin : g_chk
      localparam logic [HEC_W-1:0] PAT = ONE_C << i;
      assign flip_mask[i] = (syn == PAT);
    end else begin : g_dat
      localparam logic [HEC_W-1:0] PAT = hec_crc(ONE_D << (i - HEC_W), POLY);
      assign flip_mask[i] = (syn == PAT);
    end
  end

  assign single = |flip_mask;
endmodule

// File: rtl/hec_mode_fsm.sv
module hec_mode_fsm
  import hec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic sync_lost,
  input  logic err,
  input  logic single,
  output logic keep,
  output logic repair
);
  hec_mode_e mode_q, mode_d;

  always_comb begin
    repair = err && single && (mode_q == MODE_REPAIR);
    keep   = !err || repair;
    mode_d = mode_q;
    if (strobe) mode_d = err ? MODE_CAUTIOUS : MODE_REPAIR;
    if (sync_lost) mode_d = MODE_REPAIR;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_REPAIR;
    else     mode_q <= mode_d;
  end
endmodule

// File: rtl/hec_guard.sv
module hec_guard
  import hec_pkg::*;
#(
  parameter logic [HEC_W-1:0] POLY  = HEC_POLY,
  parameter logic [HEC_W-1:0] COSET = HEC_COSET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_lost,
  input  logic             hdr_valid,
  input  logic [HDR_W-1:0] hdr_in,
  output logic             dec_valid,
  output logic             dec_pass,
  output logic             dec_fixed,
  output logic             dec_err,
  output logic [HDR_W-1:0] hdr_out
);
  logic [HEC_W-1:0] syn;
  logic [HDR_W-1:0] flip_mask;
  logic             single, err, keep, repair;

  hec_syndrome #(.POLY(POLY), .COSET(COSET)) u_syn (
    .hdr(hdr_in), .syn(syn)
  );

  hec_bitfix #(.POLY(POLY)) u_fix (
    .syn(syn), .flip_mask(flip_mask), .single(single)
  );

  assign err = |syn;

  hec_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .strobe(hdr_valid), .sync_lost(sync_lost),
    .err(err), .single(single), .keep(keep), .repair(repair)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_pass  <= 1'b0;
      dec_fixed <= 1'b0;
      dec_err   <= 1'b0;
      hdr_out   <= '0;
    end else begin
      dec_valid <= hdr_valid;
      dec_pass  <= hdr_valid && keep;
      dec_fixed <= hdr_valid && repair;
      dec_err   <= hdr_valid && err;
      if (hdr_valid) hdr_out <= repair ? (hdr_in ^ flip_mask) : hdr_in;
    end
  end
endmodule

// File: rtl/hec_guard_chk.sv
module hec_guard_chk
  import hec_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             sync_lost,
  input logic             hdr_valid,
  input logic [HDR_W-1:0] hdr_in,
  input logic             dec_valid,
  input logic             dec_pass,
  input logic             dec_fixed,
  input logic             dec_err,
  input logic [HDR_W-1:0] hdr_out
);
  assert_strobe_decides_R1: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> dec_valid);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !dec_pass && !dec_fixed && !dec_err);
  assert_clean_passes_R3: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !dec_err |-> dec_pass && !dec_fixed);
  assert_fix_passes_R4: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_fixed |-> dec_pass && dec_err);
  assert_unfixed_drop_R5: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_err && !dec_fixed |-> !dec_pass);
  assert_no_fix_after_err_R6: assert property (@(posedge clk) disable iff (rst)
    dec_valid && $past(dec_valid) && $past(dec_err) && !$past(sync_lost, 2)
    |-> !dec_fixed);
  assert_clean_copy_R10: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !dec_fixed |-> hdr_out == $past(hdr_in));
  assert_one_bit_fix_R10: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_fixed |-> $countones(hdr_out ^ $past(hdr_in)) == 1);
endmodule

bind hec_guard hec_guard_chk u_chk (
  .clk(clk), .rst(rst), .sync_lost(sync_lost), .hdr_valid(hdr_valid),
  .hdr_in(hdr_in), .dec_valid(dec_valid), .dec_pass(dec_pass),
  .dec_fixed(dec_fixed), .dec_err(dec_err), .hdr_out(hdr_out)
);

// File: tb/hec_guard_tb.sv
`timescale 1ns/1ps
module hec_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_lost = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [39:0] hdr_in = '0;
  logic        dec_valid, dec_pass, dec_fixed, dec_err;
  logic [39:0] hdr_out;

  int checks = 0;
  int errors = 0;
  bit model_cautious = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hec_guard u_dut (
    .clk(clk), .rst(rst), .sync_lost(sync_lost), .hdr_valid(hdr_valid),
    .hdr_in(hdr_in), .dec_valid(dec_valid), .dec_pass(dec_pass),
    .dec_fixed(dec_fixed), .dec_err(dec_err), .hdr_out(hdr_out)
  );

  // Long division of data*x^8 by 0x107, then coset.
  function automatic logic [39:0] make_hdr(input logic [31:0] d);
    logic [39:0] v;
    v = {d, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (v[i]) v = v ^ (40'h107 << (i - 8));
    return {d, v[7:0] ^ 8'h55};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [39:0] act,
                     input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // nerr: number of flipped bits (0, 1 or 2); sl: sync_lost with strobe.
  task automatic send(input logic [39:0] clean, input logic [39:0] emask,
                      input int nerr, input bit sl, input string tag);
    logic [39:0] rx;
    bit exp_pass, exp_fix;
    rx = clean ^ emask;
    @(negedge clk);
    hdr_valid = 1'b1; hdr_in = rx; sync_lost = sl;
    exp_fix  = (nerr == 1) && !model_cautious;
    exp_pass = (nerr == 0) || exp_fix;
    @(negedge clk);
    hdr_valid = 1'b0; sync_lost = 1'b0;
    chk(dec_valid == 1'b1, {tag, " valid"}, {39'd0, dec_valid}, 40'd1);
    chk(dec_err == (nerr != 0), {tag, " err"}, {39'd0, dec_err}, {39'd0, nerr != 0});
    chk(dec_pass == exp_pass, {tag, " pass"}, {39'd0, dec_pass}, {39'd0, exp_pass});
    chk(dec_fixed == exp_fix, {tag, " fixed"}, {39'd0, dec_fixed}, {39'd0, exp_fix});
    chk(hdr_out == (exp_fix ? clean : rx), {tag, " hdr_out R10"}, hdr_out,
        exp_fix ? clean : rx);
    model_cautious = sl ? 1'b0 : (nerr != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] c;
    repeat (3) @(negedge clk);
    // R1 / R8: reset state is quiet
    chk(!dec_valid && !dec_pass && !dec_fixed && !dec_err, "R1 reset outputs",
        {36'd0, dec_valid, dec_pass, dec_fixed, dec_err}, 40'd0);
    rst = 1'b0;
    // R8: first single-bit error after reset is repaired
    c = make_hdr(32'h0123_4567);
    send(c, 40'd1 << 20, 1, 1'b0, "R8 repair after reset");
    send(c, 40'd0, 0, 1'b0, "R7 clean back to repair");
    // R2 / R3: clean headers of various patterns
    for (int k = 0; k < 64; k++) begin
      c = make_hdr(32'h9E37_79B9 * k ^ {k[7:0], k[7:0], k[7:0], k[7:0]});
      send(c, 40'd0, 0, 1'b0, "R2 R3 clean");
    end
    // R4 / R6 / R7: every single-bit position in both modes
    for (int i = 0; i < 40; i++) begin
      c = make_hdr(32'hA5C3_0F00 + i * 32'h0101_0107);
      send(c, 40'd1 << i, 1, 1'b0, "R4 single repaired");
      send(c, 40'd1 << i, 1, 1'b0, "R6 single dropped");
      send(c, 40'd0, 0, 1'b0, "R7 clean returns");
    end
    // R5: every two-bit pattern from repair mode
    for (int i = 0; i < 40; i++)
      for (int j = i + 1; j < 40; j++) begin
        c = make_hdr(32'h5A5A_0000 + i * 64 + j);
        send(c, (40'd1 << i) | (40'd1 << j), 2, 1'b0, "R5 double dropped");
        send(c, 40'd0, 0, 1'b0, "R7 clean after double");
      end
    // R6: errors in cautious mode keep it cautious
    c = make_hdr(32'hDEAD_BEEF);
    send(c, 40'h3, 2, 1'b0, "R5 enter cautious");
    send(c, 40'h300, 2, 1'b0, "R6 double in cautious");
    send(c, 40'd1 << 33, 1, 1'b0, "R6 single still dropped");
    // R9: sync_lost alone forces repair mode
    @(negedge clk); sync_lost = 1'b1;
    @(negedge clk); sync_lost = 1'b0;
    chk(!dec_valid, "R1 no decision without strobe", {39'd0, dec_valid}, 40'd0);
    model_cautious = 1'b0;
    send(c, 40'd1 << 9, 1, 1'b0, "R9 repair after sync loss");
    // R9: sync_lost with strobe; header judged in cautious mode
    send(c, 40'd1 << 12, 1, 1'b1, "R9 same-cycle judged cautious");
    send(c, 40'd1 << 12, 1, 1'b0, "R9 next header repaired");
    // R8: mid-stream reset returns to repair mode
    send(c, 40'h5, 2, 1'b0, "R5 cautious before reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_cautious = 1'b0;
    send(c, 40'd1 << 38, 1, 1'b0, "R8 repair after mid reset");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule